// File: doc/BRIEF.md
# Inter-Processor Interrupt Set/Clear Controller

This block collects acknowledge events from up to 32 mailbox slots and turns them into a single interrupt line for the local core. A rising edge on any event input latches a pending bit. Software can read the pending bits directly or through the enable mask, and clears them with a write-one-to-clear register. The enable bits can be loaded as a whole word, or changed one bit at a time through separate write-one-to-set and write-one-to-clear registers. Software never needs a read-modify-write sequence to change one vector.

A second path lets the local core raise interrupts toward the peer core. Writing ones to the peer register sets the matching bits of the peer interrupt output. Those bits stay high until the peer drops them through its own clear input.

The register bus is a single-cycle write strobe with a combinational read. Every register is 32 bits wide and sits at a byte offset inside an 8-bit window.

Top module: `ipc_irq_ctrl`

## Requirements
- R1: After reset, the pending, enable and peer bits are all zero, `irq_o` is low, and every register reads 0.
- R2: A 0-to-1 change of `ack_evt_i[n]` sets pending bit n at the next clock edge. An input held high does not set the bit again after it has been cleared. Pending bits read at offset 0x00.
- R3: A write to offset 0x0C clears every pending bit whose data bit is 1. Bits written as 0 are left unchanged, and writing all ones clears every vector.
- R4: If a clear of bit n and a new rising edge on `ack_evt_i[n]` fall in the same cycle, bit n ends up set.
- R5: A write to offset 0x04 loads the enable bits with the written word. Writing 0 masks every vector.
- R6: A write to offset 0x10 sets the enable bits whose data bit is 1 and leaves the other enable bits unchanged.
- R7: A write to offset 0x14 clears the enable bits whose data bit is 1 and leaves the other enable bits unchanged.
- R8: Reading offset 0x04 returns the current enable bits, whichever of offsets 0x04, 0x10 or 0x14 last changed them.
- R9: Offset 0x08 reads pending AND enable. `irq_o` is the OR of those status bits and follows them in the same cycle the state changes.
- R10: A write to offset 0x18 sets the matching bits of `peer_irq_o` at the next clock edge. Offset 0x18 reads the current peer bits.
- R11: A peer bit stays high until its `peer_clr_i` bit is high at a clock edge. If a set write and a peer clear land on the same bit in the same cycle, the bit stays set.
- R12: Writes to offsets 0x00 and 0x08, and to any unmapped offset, change no state. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ack_evt_i | input | 32 | Acknowledge event inputs, one per mailbox slot |
| peer_clr_i | input | 32 | Peer-side clear, one per peer vector |
| irq_o | output | 1 | Combined local interrupt |
| peer_irq_o | output | 32 | Interrupt vectors toward the peer core |

## Verification
A wrong pending bit shows on the pending read and, once that vector is enabled, on the status read and on `irq_o`, all in the cycle after the offending edge. A wrong enable bit shows at once on the enable read. It also shows on `irq_o` the first time a matching pending bit is set or cleared, so the tests pair every enable change with a known pending pattern. A peer bit that drops early or sticks shows on `peer_irq_o` one clock after the write or clear that should have set or dropped it.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    localparam int IPC_NVEC   = 32;
    localparam int IPC_ADDR_W = 8;

    localparam logic [7:0] OFF_PEND    = 8'h00;
    localparam logic [7:0] OFF_ENABLE  = 8'h04;
    localparam logic [7:0] OFF_STATUS  = 8'h08;
    localparam logic [7:0] OFF_CLEAR   = 8'h0C;
    localparam logic [7:0] OFF_EN_SET  = 8'h10;
    localparam logic [7:0] OFF_EN_CLR  = 8'h14;
    localparam logic [7:0] OFF_PEER    = 8'h18;

    typedef struct packed {
        logic en_load;
        logic en_set;
        logic en_clr;
        logic pend_clr;
        logic peer_set;
    } ipc_wr_t;
endpackage

// File: rtl/ipc_bus_decode.sv
module ipc_bus_decode
    import ipc_pkg::*;
#(
    parameter int ADDR_W = IPC_ADDR_W
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output ipc_wr_t           wr_o
);
    always_comb begin
        wr_o          = '0;
        wr_o.en_load  = bus_wr && (bus_addr == ADDR_W'(OFF_ENABLE));
        wr_o.en_set   = bus_wr && (bus_addr == ADDR_W'(OFF_EN_SET));
        wr_o.en_clr   = bus_wr && (bus_addr == ADDR_W'(OFF_EN_CLR));
        wr_o.pend_clr = bus_wr && (bus_addr == ADDR_W'(OFF_CLEAR));
        wr_o.peer_set = bus_wr && (bus_addr == ADDR_W'(OFF_PEER));
    end
endmodule

// File: rtl/ipc_evt_edge.sv
module ipc_evt_edge #(
    parameter int NVEC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NVEC-1:0] evt_i,
    output logic [NVEC-1:0] evt_q,
    output logic [NVEC-1:0] rise_o
);
    logic [NVEC-1:0] evt_d;

    always_comb begin
        evt_d = evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end

    for (genvar g = 0; g < NVEC; g++) begin : g_rise
        assign rise_o[g] = evt_i[g] & ~evt_q[g];
    end
endmodule

// File: rtl/ipc_ack_bank.sv
module ipc_ack_bank
    import ipc_pkg::*;
#(
    parameter int NVEC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ipc_wr_t         wr_i,
    input  logic [NVEC-1:0] wdata_i,
    input  logic [NVEC-1:0] rise_i,
    output logic [NVEC-1:0] pend_o,
    output logic [NVEC-1:0] en_o
);
    typedef struct packed {
        logic [NVEC-1:0] pend;
        logic [NVEC-1:0] en;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i.pend_clr) st_d.pend = st_q.pend & ~wdata_i;
        st_d.pend = st_d.pend | rise_i;
        if (wr_i.en_load) st_d.en = wdata_i;
        if (wr_i.en_set)  st_d.en = st_q.en | wdata_i;
        if (wr_i.en_clr)  st_d.en = st_q.en & ~wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;
endmodule

// File: rtl/ipc_peer_bank.sv
module ipc_peer_bank
    import ipc_pkg::*;
#(
    parameter int NVEC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ipc_wr_t         wr_i,
    input  logic [NVEC-1:0] wdata_i,
    input  logic [NVEC-1:0] peer_clr_i,
    output logic [NVEC-1:0] peer_o
);
    logic [NVEC-1:0] peer_d, peer_q;

    always_comb begin
        peer_d = peer_q & ~peer_clr_i;
        if (wr_i.peer_set) peer_d = peer_d | wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) peer_q <= '0;
        else        peer_q <= peer_d;
    end

    assign peer_o = peer_q;
endmodule

// File: rtl/ipc_irq_ctrl.sv
module ipc_irq_ctrl
    import ipc_pkg::*;
#(
    parameter int NVEC   = IPC_NVEC,
    parameter int ADDR_W = IPC_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NVEC-1:0]   bus_wdata,
    output logic [NVEC-1:0]   bus_rdata,
    input  logic [NVEC-1:0]   ack_evt_i,
    input  logic [NVEC-1:0]   peer_clr_i,
    output logic              irq_o,
    output logic [NVEC-1:0]   peer_irq_o
);
    ipc_wr_t         wr_w;
    logic [NVEC-1:0] evt_w, rise_w, pend_w, en_w, stat_w;

    ipc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wr_o     (wr_w)
    );

    ipc_evt_edge #(.NVEC(NVEC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (ack_evt_i),
        .evt_q  (evt_w),
        .rise_o (rise_w)
    );

    ipc_ack_bank #(.NVEC(NVEC)) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_w),
        .wdata_i (bus_wdata),
        .rise_i  (rise_w),
        .pend_o  (pend_w),
        .en_o    (en_w)
    );

    ipc_peer_bank #(.NVEC(NVEC)) u_peer (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_w),
        .wdata_i    (bus_wdata),
        .peer_clr_i (peer_clr_i),
        .peer_o     (peer_irq_o)
    );

    assign stat_w = pend_w & en_w;
    assign irq_o  = |stat_w;

    always_comb begin
        bus_rdata = '0;
        if      (bus_addr == ADDR_W'(OFF_PEND))   bus_rdata = pend_w;
        else if (bus_addr == ADDR_W'(OFF_ENABLE)) bus_rdata = en_w;
        else if (bus_addr == ADDR_W'(OFF_STATUS)) bus_rdata = stat_w;
        else if (bus_addr == ADDR_W'(OFF_PEER))   bus_rdata = peer_irq_o;
    end
endmodule

// File: rtl/ipc_irq_ctrl_chk.sv
module ipc_irq_ctrl_chk
    import ipc_pkg::*;
#(
    parameter int NVEC   = IPC_NVEC,
    parameter int ADDR_W = IPC_ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NVEC-1:0]   bus_wdata,
    input logic [NVEC-1:0]   ack_evt_i,
    input logic [NVEC-1:0]   peer_clr_i,
    input logic              irq_o,
    input logic [NVEC-1:0]   peer_irq_o,
    input logic [NVEC-1:0]   pend_w,
    input logic [NVEC-1:0]   en_w,
    input logic [NVEC-1:0]   evt_w
);
    logic [NVEC-1:0] new_edge;
    assign new_edge = ack_evt_i & ~evt_w;

    // R2 R4
    pend_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_w & $past(new_edge)) == $past(new_edge)));

    // R6
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_EN_SET))
        |=> ((en_w & $past(bus_wdata)) == $past(bus_wdata)));

    // R7
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_EN_CLR))
        |=> ((en_w & $past(bus_wdata)) == '0));

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_w == '0) |-> !irq_o);

    // R10
    peer_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_PEER))
        |=> ((peer_irq_o & $past(bus_wdata)) == $past(bus_wdata)));

    // R11
    peer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(peer_irq_o) & ~peer_irq_o) & ~$past(peer_clr_i)) == '0));
endmodule

bind ipc_irq_ctrl ipc_irq_ctrl_chk #(.NVEC(NVEC), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .ack_evt_i  (ack_evt_i),
    .peer_clr_i (peer_clr_i),
    .irq_o      (irq_o),
    .peer_irq_o (peer_irq_o),
    .pend_w     (pend_w),
    .en_w       (en_w),
    .evt_w      (evt_w)
);

// File: tb/test_ipc_irq_ctrl.sv
module test_ipc_irq_ctrl;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] ack_evt_i = '0;
    logic [31:0] peer_clr_i = '0;
    logic        irq_o;
    logic [31:0] peer_irq_o;

    int errors = 0;
    int checks = 0;

    ipc_irq_ctrl i_ipc_irq_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ack_evt_i  (ack_evt_i),
        .peer_clr_i (peer_clr_i),
        .irq_o      (irq_o),
        .peer_irq_o (peer_irq_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_evt(input logic [31:0] m);
        @(negedge clk); ack_evt_i = m;
        @(negedge clk); ack_evt_i = '0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        bread(8'h00, v); chk("R1 pending", v, 0);
        bread(8'h04, v); chk("R1 enable", v, 0);
        bread(8'h18, v); chk("R1 peer read", v, 0);
        chk("R1 peer out", peer_irq_o, 0);
        chk("R1 irq", {31'd0, irq_o}, 0);
    endtask

    task automatic t_latch_clear;
        logic [31:0] v;
        pulse_evt(32'h8000_0011);
        bread(8'h00, v); chk("R2 latch", v, 32'h8000_0011);
        bwrite(8'h0C, 32'h0000_0001);
        bread(8'h00, v); chk("R3 partial clear", v, 32'h8000_0010);
        // held level: no re-set after clear
        @(negedge clk); ack_evt_i = 32'h0000_0100;
        @(negedge clk);
        bread(8'h00, v); chk("R2 held latch", v, 32'h8000_0110);
        bwrite(8'h0C, 32'h0000_0100);
        @(negedge clk);
        bread(8'h00, v); chk("R2 held no reset", v, 32'h8000_0010);
        ack_evt_i = '0;
        bwrite(8'h0C, 32'hFFFF_FFFF);
        bread(8'h00, v); chk("R3 clear all", v, 0);
    endtask

    task automatic t_race;
        logic [31:0] v;
        pulse_evt(32'h0000_0030);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h0000_0030;
        ack_evt_i = 32'h0000_0010;
        @(negedge clk);
        bus_wr = 1'b0; ack_evt_i = '0;
        bread(8'h00, v); chk("R4 event wins", v, 32'h0000_0010);
        bwrite(8'h0C, 32'hFFFF_FFFF);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        bwrite(8'h04, 32'h0F0F_0000);
        bread(8'h04, v); chk("R5 load", v, 32'h0F0F_0000);
        bwrite(8'h10, 32'h0000_00A0);
        bread(8'h04, v); chk("R6 set", v, 32'h0F0F_00A0);
        bwrite(8'h14, 32'h0100_0080);
        bread(8'h04, v); chk("R7 clr", v, 32'h0E0F_0020);
        bread(8'h04, v); chk("R8 readback", v, 32'h0E0F_0020);
        bwrite(8'h04, 32'h0);
        bread(8'h04, v); chk("R5 mask all", v, 0);
    endtask

    task automatic t_status;
        logic [31:0] v;
        pulse_evt(32'h0000_0081);
        chk("R9 masked irq", {31'd0, irq_o}, 0);
        bwrite(8'h10, 32'h0000_0080);
        bread(8'h08, v); chk("R9 status", v, 32'h0000_0080);
        chk("R9 irq high", {31'd0, irq_o}, 1);
        bwrite(8'h0C, 32'h0000_0080);
        chk("R9 irq after clear", {31'd0, irq_o}, 0);
        bread(8'h08, v); chk("R9 status after clear", v, 0);
        bwrite(8'h0C, 32'hFFFF_FFFF);
        bwrite(8'h04, 32'h0);
    endtask

    task automatic t_peer;
        logic [31:0] v;
        bwrite(8'h18, 32'h0000_0006);
        chk("R10 peer out", peer_irq_o, 32'h0000_0006);
        bread(8'h18, v); chk("R10 peer read", v, 32'h0000_0006);
        repeat (3) @(negedge clk);
        chk("R11 peer held", peer_irq_o, 32'h0000_0006);
        peer_clr_i = 32'h0000_0002;
        @(negedge clk); peer_clr_i = '0;
        chk("R11 peer clr", peer_irq_o, 32'h0000_0004);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h18; bus_wdata = 32'h0000_0001;
        peer_clr_i = 32'h0000_0005;
        @(negedge clk);
        bus_wr = 1'b0; peer_clr_i = '0;
        chk("R11 set wins", peer_irq_o, 32'h0000_0001);
        peer_clr_i = 32'hFFFF_FFFF;
        @(negedge clk); peer_clr_i = '0;
    endtask

    task automatic t_ignored;
        logic [31:0] v;
        pulse_evt(32'h0000_4000);
        bwrite(8'h00, 32'hFFFF_FFFF);
        bwrite(8'h08, 32'hFFFF_FFFF);
        bwrite(8'h3C, 32'hFFFF_FFFF);
        bread(8'h00, v); chk("R12 pending intact", v, 32'h0000_4000);
        bread(8'h04, v); chk("R12 enable intact", v, 0);
        chk("R12 peer intact", peer_irq_o, 0);
        bread(8'h3C, v); chk("R12 unmapped read", v, 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch_clear();
        t_race();
        t_enable();
        t_status();
        t_peer();
        t_ignored();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule